// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a DDR SDRAM device from the moment reset is released until the device can accept normal traffic. First it waits through a long power-on settling interval, during which it drives only no-operation commands. The length of this interval is a parameter, so a simulation build can use a short count. Clock enable is raised during the settling interval. The block then steps through a fixed list of bank-close, mode-load and refresh commands, with a programmable number of idle cycles after each one.

The list is fixed. It closes all banks, loads the extended mode word, and loads the base mode word with the DLL-reset bit set. It then waits a fixed 200 idle cycles for the DLL to lock. After that it closes all banks again, issues two refreshes, and loads the base mode word a second time with the DLL-reset bit cleared. Once the gap after that last load has run out, a ready flag rises toward the user logic. From then on the sequencer idles until it is reset again.

Commands are encoded on {cs_n, ras_n, cas_n, we_n}: idle (NOP) 0111, close-all-banks 0010, refresh 0001, mode load 0000. All outputs are registered.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low, cs_n, ras_n, cas_n and we_n are all 1, cke is 0 and init_done is 0.
- R2: After reset release, the pins show exactly STARTUP_CYCLES cycles of NOP (0111) before the first other command. Every NOP cycle drives bank address 0 and row address 0.
- R3: cke is high on exactly CKE_LEAD cycles before the first close-all command. Once high, cke stays high until the next reset.
- R4: The first command is close-all-banks (0010), with row address bit AP_BIT set, all other row bits 0, and bank address 0.
- R5: Exactly T_RP NOP cycles later comes a mode load (0000) with bank address 1 and row address EXT_MODE_WORD. Exactly T_MRD NOP cycles after that comes a mode load with bank address 0 and row address MODE_WORD with bit DLL_RST_BIT set.
- R6: After that first base mode load come exactly 200 NOP cycles, whatever the timing parameters are set to.
- R7: Next comes close-all-banks (bit AP_BIT set), then T_RP NOPs, then refresh (0001), then T_RFC NOPs, then a second refresh. After a further T_RFC NOPs comes a mode load with bank 0 and MODE_WORD with bit DLL_RST_BIT cleared. No two commands are ever on adjacent cycles.
- R8: init_done stays 0 throughout the sequence. It rises on the first cycle after the T_MRD NOP cycles that follow the final mode load.
- R9: Once init_done is high, it and cke stay high and only NOPs are driven. The sequence is not repeated until the next reset.
- R10: A reset asserted on any cycle, including a command cycle or the cycle in which init_done rises, returns the outputs to the R1 state at once. The next release starts the whole sequence again from its full start-up interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Device clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank address |
| addr_o | output | ROW_W | Row address / mode word |
| init_done_o | output | 1 | Device ready for normal traffic |

## Verification
Two events can land in the same cycle: a reset, and either a command issue or the rise of init_done. The bench starts a run and aborts it with reset exactly on the cycles of the first close-all, the first mode load and the init_done rise. It also aborts at random cycles, with random reset lengths, drawn from a fixed seed. Each abort is judged by checking that the pins fall to the reset state straight away. The run that follows must then match the complete expected cycle-by-cycle trace from the first NOP onward.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } cmd_e;

  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  localparam int unsigned DLL_LOCK_GAP = 200;
  localparam int unsigned NUM_STEPS    = 7;
  localparam int unsigned STEP_W       = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RESET_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(RESET_VAL);
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R2: the counter is never asked to step below zero
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
  import ddr_init_pkg::*;
#(
  parameter int unsigned ROW_W         = 13,
  parameter int unsigned BANK_W        = 2,
  parameter int unsigned CNT_W         = 8,
  parameter int unsigned AP_BIT        = 10,
  parameter int unsigned DLL_RST_BIT   = 8,
  parameter int unsigned MODE_WORD     = 32'h032,
  parameter int unsigned EXT_MODE_WORD = 32'h000,
  parameter int unsigned T_RP          = 3,
  parameter int unsigned T_RFC         = 10,
  parameter int unsigned T_MRD         = 2
) (
  input  logic [STEP_W-1:0] step_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [CNT_W-1:0]  gap_o
);

  localparam logic [ROW_W-1:0] AP_MASK  = ROW_W'(1) << AP_BIT;
  localparam logic [ROW_W-1:0] DLL_MASK = ROW_W'(1) << DLL_RST_BIT;
  localparam logic [ROW_W-1:0] MR_BASE  = ROW_W'(MODE_WORD);
  localparam logic [ROW_W-1:0] EMR_WORD = ROW_W'(EXT_MODE_WORD);

  // gap_o carries the idle count minus one, as loaded into the timer
  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    gap_o  = '0;
    case (step_i)
      3'd0: begin cmd_o = CMD_PRE; addr_o = AP_MASK;             gap_o = CNT_W'(T_RP - 1);         end
      3'd1: begin cmd_o = CMD_LMR; addr_o = EMR_WORD; ba_o = BANK_W'(1);
                  gap_o = CNT_W'(T_MRD - 1); end
      3'd2: begin cmd_o = CMD_LMR; addr_o = MR_BASE | DLL_MASK;  gap_o = CNT_W'(DLL_LOCK_GAP - 1); end
      3'd3: begin cmd_o = CMD_PRE; addr_o = AP_MASK;             gap_o = CNT_W'(T_RP - 1);         end
      3'd4: begin cmd_o = CMD_REF;                               gap_o = CNT_W'(T_RFC - 1);        end
      3'd5: begin cmd_o = CMD_REF;                               gap_o = CNT_W'(T_RFC - 1);        end
      3'd6: begin cmd_o = CMD_LMR; addr_o = MR_BASE & ~DLL_MASK; gap_o = CNT_W'(T_MRD - 1);        end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 25_000_000,
  parameter int unsigned CKE_LEAD       = 1000,
  parameter int unsigned T_RP           = 3,
  parameter int unsigned T_RFC          = 10,
  parameter int unsigned T_MRD          = 2,
  parameter int unsigned ROW_W          = 13,
  parameter int unsigned BANK_W         = 2,
  parameter int unsigned AP_BIT         = 10,
  parameter int unsigned DLL_RST_BIT    = 8,
  parameter int unsigned MODE_WORD      = 32'h032,
  parameter int unsigned EXT_MODE_WORD  = 32'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              init_done_o
);

  localparam int unsigned CNT_MAX = max2(max2(STARTUP_CYCLES, DLL_LOCK_GAP),
                                         max2(max2(T_RP, T_RFC), T_MRD));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // sequencing state
  phase_e             phase_q, phase_d;
  logic [STEP_W-1:0]  step_q, step_d;

  // timer
  logic [CNT_W-1:0]   tmr_cnt;
  logic               tmr_zero;
  logic               tmr_load, tmr_dec;

  // step decode
  cmd_e               tbl_cmd;
  logic [BANK_W-1:0]  tbl_ba;
  logic [ROW_W-1:0]   tbl_addr;
  logic [CNT_W-1:0]   tbl_gap;

  // registered pins
  cmd_e               cmd_q, cmd_d;
  logic [BANK_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0]   addr_q, addr_d;
  logic               cke_q, cke_d;
  logic               done_q, done_d;

  ddr_init_timer #(
    .CNT_W     (CNT_W),
    .RESET_VAL (STARTUP_CYCLES - 1)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tbl_gap),
    .dec_i      (tmr_dec),
    .cnt_o      (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  ddr_init_steps #(
    .ROW_W         (ROW_W),
    .BANK_W        (BANK_W),
    .CNT_W         (CNT_W),
    .AP_BIT        (AP_BIT),
    .DLL_RST_BIT   (DLL_RST_BIT),
    .MODE_WORD     (MODE_WORD),
    .EXT_MODE_WORD (EXT_MODE_WORD),
    .T_RP          (T_RP),
    .T_RFC         (T_RFC),
    .T_MRD         (T_MRD)
  ) steps_i (
    .step_i (step_q),
    .cmd_o  (tbl_cmd),
    .ba_o   (tbl_ba),
    .addr_o (tbl_addr),
    .gap_o  (tbl_gap)
  );

  assign tmr_load = (phase_q == PH_ISSUE);
  assign tmr_dec  = (phase_q == PH_WAIT) && !tmr_zero;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    case (phase_q)
      PH_WAIT: begin
        if (tmr_zero) begin
          phase_d = (step_q == STEP_W'(NUM_STEPS)) ? PH_DONE : PH_ISSUE;
        end
      end
      PH_ISSUE: begin
        step_d  = step_q + STEP_W'(1);
        phase_d = PH_WAIT;
      end
      PH_DONE: ;
      default: phase_d = PH_WAIT;
    endcase
  end

  always_comb begin
    if (phase_q == PH_ISSUE) begin
      cmd_d  = tbl_cmd;
      ba_d   = tbl_ba;
      addr_d = tbl_addr;
    end else begin
      cmd_d  = CMD_NOP;
      ba_d   = '0;
      addr_d = '0;
    end
    cke_d  = cke_q | (tmr_cnt < CNT_W'(CKE_LEAD));
    done_d = done_q | (phase_q == PH_DONE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      step_q  <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= CMD_DESEL;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      cke_q  <= cke_d;
      done_q <= done_d;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign cke_o       = cke_q;
  assign init_done_o = done_q;

  // ---------------- assertions ----------------
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (cs_n_o && ras_n_o && cas_n_o && we_n_o && !cke_o && !init_done_o));

  assert_cke_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  assert_cke_before_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |-> cke_o);

  assert_pre_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> addr_o[AP_BIT]);

  assert_cmd_then_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |=> (cmd_q == CMD_NOP));

  assert_nop_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_NOP) |-> (addr_o == '0 && ba_o == '0));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> (cmd_q == CMD_NOP && cke_o));

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

  localparam int S     = 300;
  localparam int L     = 20;
  localparam int TRP   = 3;
  localparam int TRFC  = 9;
  localparam int TMRD  = 2;
  localparam int RW    = 13;
  localparam int BW    = 2;
  localparam int APB   = 10;
  localparam int DLLB  = 8;
  localparam int MODEW = 'h032;
  localparam int EXTW  = 'h004;
  localparam int LOCK  = 200;

  localparam int T_PRE1 = S + 1;
  localparam int T_EMR  = T_PRE1 + 1 + TRP;
  localparam int T_MR1  = T_EMR + 1 + TMRD;
  localparam int T_PRE2 = T_MR1 + 1 + LOCK;
  localparam int T_REF1 = T_PRE2 + 1 + TRP;
  localparam int T_REF2 = T_REF1 + 1 + TRFC;
  localparam int T_MR2  = T_REF2 + 1 + TRFC;
  localparam int T_DONE = T_MR2 + 1 + TMRD;
  localparam int T_CKE  = S - L + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BW-1:0] ba;
  logic [RW-1:0] addr;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .STARTUP_CYCLES (S), .CKE_LEAD (L), .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD),
    .ROW_W (RW), .BANK_W (BW), .AP_BIT (APB), .DLL_RST_BIT (DLLB),
    .MODE_WORD (MODEW), .EXT_MODE_WORD (EXTW)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cke_o (cke), .cs_n_o (cs_n), .ras_n_o (ras_n),
    .cas_n_o (cas_n), .we_n_o (we_n), .ba_o (ba), .addr_o (addr), .init_done_o (done)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void exp_at(input int t, output logic [3:0] c, output logic [1:0] b,
                                 output logic [RW-1:0] a, output string tag);
    c = 4'b0111; b = 2'd0; a = '0;
    if (t < T_PRE1) tag = "R2";
    else if (t == T_PRE1) begin tag = "R4"; c = 4'b0010; a = RW'(1 << APB); end
    else if (t <= T_MR1) begin
      tag = "R5";
      if (t == T_EMR) begin c = 4'b0000; b = 2'd1; a = RW'(EXTW); end
      if (t == T_MR1) begin c = 4'b0000; a = RW'(MODEW | (1 << DLLB)); end
    end
    else if (t < T_PRE2) tag = "R6";
    else if (t <= T_MR2) begin
      tag = "R7";
      if (t == T_PRE2) begin c = 4'b0010; a = RW'(1 << APB); end
      if (t == T_REF1 || t == T_REF2) c = 4'b0001;
      if (t == T_MR2) begin c = 4'b0000; a = RW'(MODEW & ~(1 << DLLB)); end
    end
    else tag = "R9";
  endfunction

  // caller stands just after a falling edge
  task automatic run_seq(input int abort_at, input int hold);
    logic [3:0] c;
    logic [1:0] b;
    logic [RW-1:0] a;
    string tag;
    rst_n = 1'b0;
    repeat (hold) begin
      @(negedge clk);
      check("R1", "cs_n", 32'(cs_n), 32'd1);
      check("R1", "cke", 32'(cke), 32'd0);
      check("R1", "done", 32'(done), 32'd0);
    end
    rst_n = 1'b1;
    for (int t = 1; t <= T_DONE + 40; t++) begin
      @(negedge clk);
      exp_at(t, c, b, a, tag);
      check(tag, "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(c));
      check(tag, "ba", 32'(ba), 32'(b));
      check(tag, "addr", 32'(addr), 32'(a));
      check("R3", "cke", 32'(cke), 32'(t >= T_CKE));
      check((t > T_DONE) ? "R9" : "R8", "done", 32'(done), 32'(t >= T_DONE));
      if (t == abort_at) begin
        rst_n = 1'b0;
        #1;
        check("R10", "cs_n", 32'(cs_n), 32'd1);
        check("R10", "cke", 32'(cke), 32'd0);
        check("R10", "done", 32'(done), 32'd0);
        break;
      end
    end
  endtask

  initial begin
    #2 rst_n = 1'b0;
    void'($urandom(32'd2024));
    @(negedge clk);
    run_seq(0, 3);              // full sequence
    run_seq(T_PRE1, 2);         // R10: reset on a command cycle
    run_seq(T_MR1, 1);          // R10: reset on the DLL-reset load
    run_seq(T_DONE, 4);         // R10: reset as init_done rises
    for (int i = 0; i < 8; i++) begin
      run_seq(int'($urandom_range(T_DONE + 5, 1)), int'($urandom_range(6, 1)));
    end
    run_seq(0, 2);              // clean restart after the aborts
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule